// File: doc/BRIEF.md
# DDR SDRAM Command Legality Checker

This block is a passive watcher for the command bus of a four-bank DDR SDRAM. On every rising clock edge it samples the clock-enable, chip-select, row-strobe, column-strobe and write-enable lines, together with address bit 10 and the bank address. It turns them into one command code and decides whether that command is legal in the current state of the banks. Both results appear on registered outputs one clock after the command is sampled.

For each bank the block tracks whether a row is open. It also keeps a down-counter that holds the bank locked after a precharge, after a read with auto-precharge or after a write with auto-precharge. The lock lengths are set by the burst length, the precharge period and the write-recovery period, each given in clock cycles as a parameter. A command that reaches a bank too early, or that does not fit the bank's open or closed state, raises a violation flag and reports the bank at fault. A violating command is treated as if it never reached the memory.

Top module: `ddr_cmd_guard`

## Requirements
- R1: With chip-select high, the command is decoded as deselect (code 0). It never raises a violation and leaves every bank unchanged.
- R2: Decoded command codes: 1 no-op, 2 mode register write (BA0 low), 3 extended mode register write (BA0 high), 4 refresh, 5 activate, 6 single-bank precharge, 7 precharge-all, 8 read, 9 read with auto-precharge, 10 write, 11 write with auto-precharge, 12 burst stop. Pins for chip-select low are written as RAS/CAS/WE: LLL mode write, LLH refresh, LHH activate, LHL precharge, HLH read, HLL write, HHL burst stop, HHH no-op. For precharge, read and write, A10 high selects the all-bank or auto-precharge form. The code and the violation result are registered and appear one clock after the sampling edge.
- R3: A legal read with auto-precharge sampled at cycle n closes the bank. Any command to that bank in cycles n+1 to n+BURST_LEN/2+T_RP-1 is a violation. From cycle n+BURST_LEN/2+T_RP on, the bank can be activated again.
- R4: A legal write with auto-precharge sampled at cycle n closes the bank. Any command to that bank in cycles n+1 to n+BURST_LEN/2+1+T_WR+T_RP-1 is a violation. From cycle n+BURST_LEN/2+1+T_WR+T_RP on, the bank can be activated again.
- R5: A lock on one bank does not affect commands to the other banks.
- R6: A precharge with A10 low closes only the bank named by BA. A precharge with A10 high closes every open bank and ignores BA. A bank closed by a precharge at cycle n is locked through cycle n+T_RP-1.
- R7: A mode register write or an extended mode register write is a violation while any bank is open or locked.
- R8: An activate to an open bank is a violation. A read or a write to a closed bank is a violation.
- R9: A refresh is a violation while any bank is open or locked.
- R10: A command that raises a violation changes no bank state.
- R11: The violation bank output names the bank that BA targets. For mode register write, refresh and precharge-all it names the lowest-numbered bank at fault.
- R12: A command sampled while clock-enable was low at the previous edge is decoded as held (code 13). It is ignored and raises no violation.
- R13: Reset closes and unlocks every bank. It clears the outputs to code 0 with no violation and bank 0, and it marks clock-enable as previously low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Command clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| cke | input | 1 | Memory clock-enable line |
| cs_n | input | 1 | Chip-select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write-enable, active low |
| a10 | input | 1 | Address bit 10 (auto-precharge / all-bank select) |
| ba | input | BA_W | Bank address |
| cmd_code | output | 4 | Decoded command of the previous cycle |
| viol | output | 1 | Previous command was illegal |
| viol_bank | output | BA_W | Bank at fault for the flagged command |

## Verification
A wrong bank state (a stale open flag, or a counter loaded one cycle short or long) has no port of its own. It shows up only as the violation flag on the next command that reaches that bank. So the bench follows each state change with probe commands one cycle apart and checks the exact cycle at which a lock ends. The lock windows are walked cycle by cycle using counts derived from the parameters, so an off-by-one in the read or write window is reported at the first cycle where it differs. Ignored commands are checked the same way: after a flagged, deselected or held activate, the next activate to the same bank must be legal.

// File: rtl/ddr_cmd_guard_pkg.sv
package ddr_cmd_guard_pkg;

    typedef enum logic [3:0] {
        CMD_DESEL = 4'd0,
        CMD_NOP   = 4'd1,
        CMD_MRS   = 4'd2,
        CMD_EMRS  = 4'd3,
        CMD_REF   = 4'd4,
        CMD_ACT   = 4'd5,
        CMD_PRE   = 4'd6,
        CMD_PREA  = 4'd7,
        CMD_RD    = 4'd8,
        CMD_RDA   = 4'd9,
        CMD_WR    = 4'd10,
        CMD_WRA   = 4'd11,
        CMD_BST   = 4'd12,
        CMD_HOLD  = 4'd13
    } cmd_e;

endpackage

// File: rtl/ddr_cmd_decode.sv
module ddr_cmd_decode
    import ddr_cmd_guard_pkg::*;
(
    input  logic cke_prev,
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    input  logic a10,
    input  logic ba0,
    output cmd_e cmd
);

    always_comb begin
        cmd = CMD_NOP;
        if (!cke_prev) begin
            cmd = CMD_HOLD;
        end else if (cs_n) begin
            cmd = CMD_DESEL;
        end else begin
            unique case ({ras_n, cas_n, we_n})
                3'b000: cmd = ba0 ? CMD_EMRS : CMD_MRS;
                3'b001: cmd = CMD_REF;
                3'b011: cmd = CMD_ACT;
                3'b010: cmd = a10 ? CMD_PREA : CMD_PRE;
                3'b101: cmd = a10 ? CMD_RDA : CMD_RD;
                3'b100: cmd = a10 ? CMD_WRA : CMD_WR;
                3'b110: cmd = CMD_BST;
                default: cmd = CMD_NOP;
            endcase
        end
    end

endmodule

// File: rtl/ddr_bank_timer.sv
module ddr_bank_timer #(
    parameter int RD_LOCK  = 5,
    parameter int WR_LOCK  = 8,
    parameter int PRE_LOCK = 3,
    localparam int MAX_LOCK = (WR_LOCK > RD_LOCK) ? WR_LOCK : RD_LOCK,
    localparam int CNT_W    = $clog2(MAX_LOCK + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic op_act,
    input  logic op_pre,
    input  logic op_rd_ap,
    input  logic op_wr_ap,
    output logic active_o,
    output logic locked_o
);

    localparam logic [CNT_W-1:0] RD_LOAD  = CNT_W'(RD_LOCK - 1);
    localparam logic [CNT_W-1:0] WR_LOAD  = CNT_W'(WR_LOCK - 1);
    localparam logic [CNT_W-1:0] PRE_LOAD = CNT_W'(PRE_LOCK - 1);

    typedef struct packed {
        logic             active;
        logic [CNT_W-1:0] cnt;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (bank_q.cnt != '0) begin
            bank_d.cnt = bank_q.cnt - 1'b1;
        end
        if (op_act) begin
            bank_d.active = 1'b1;
        end else if (op_rd_ap) begin
            bank_d.active = 1'b0;
            bank_d.cnt    = RD_LOAD;
        end else if (op_wr_ap) begin
            bank_d.active = 1'b0;
            bank_d.cnt    = WR_LOAD;
        end else if (op_pre && bank_q.active) begin
            bank_d.active = 1'b0;
            bank_d.cnt    = PRE_LOAD;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign active_o = bank_q.active;
    assign locked_o = (bank_q.cnt != '0);

    // R8 / R10: the guard only opens a closed, free bank
    p_act_when_free_r8: assert property (@(posedge clk) disable iff (!rst_n)
        op_act |-> (!active_o && !locked_o));

    // R3: an accepted read with auto-precharge leaves the bank closed and locked
    p_rd_ap_locks_r3: assert property (@(posedge clk) disable iff (!rst_n)
        op_rd_ap |=> (locked_o && !active_o));

    // R4: an accepted write with auto-precharge leaves the bank closed and locked
    p_wr_ap_locks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        op_wr_ap |=> (locked_o && !active_o));

    // R6: an open bank never carries a running lock
    p_open_unlocked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        active_o |-> !locked_o);

endmodule

// File: rtl/ddr_cmd_guard.sv
module ddr_cmd_guard
    import ddr_cmd_guard_pkg::*;
#(
    parameter int BURST_LEN = 4,
    parameter int T_RP      = 3,
    parameter int T_WR      = 2,
    parameter int BA_W      = 2,
    localparam int NUM_BANKS = 1 << BA_W,
    localparam int RD_LOCK   = BURST_LEN / 2 + T_RP,
    localparam int WR_LOCK   = BURST_LEN / 2 + 1 + T_WR + T_RP
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cke,
    input  logic            cs_n,
    input  logic            ras_n,
    input  logic            cas_n,
    input  logic            we_n,
    input  logic            a10,
    input  logic [BA_W-1:0] ba,
    output logic [3:0]      cmd_code,
    output logic            viol,
    output logic [BA_W-1:0] viol_bank
);

    typedef struct packed {
        cmd_e            code;
        logic            viol;
        logic [BA_W-1:0] bank;
        logic            cke;
    } out_t;

    out_t state_d, state_q;
    cmd_e dec_cmd;

    logic [NUM_BANKS-1:0] bank_active, bank_locked, bank_busy;
    logic [NUM_BANKS-1:0] op_act, op_pre, op_rd_ap, op_wr_ap;

    ddr_cmd_decode u_decode (
        .cke_prev (state_q.cke),
        .cs_n     (cs_n),
        .ras_n    (ras_n),
        .cas_n    (cas_n),
        .we_n     (we_n),
        .a10      (a10),
        .ba0      (ba[0]),
        .cmd      (dec_cmd)
    );

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        ddr_bank_timer #(
            .RD_LOCK  (RD_LOCK),
            .WR_LOCK  (WR_LOCK),
            .PRE_LOCK (T_RP)
        ) u_timer (
            .clk      (clk),
            .rst_n    (rst_n),
            .op_act   (op_act[g]),
            .op_pre   (op_pre[g]),
            .op_rd_ap (op_rd_ap[g]),
            .op_wr_ap (op_wr_ap[g]),
            .active_o (bank_active[g]),
            .locked_o (bank_locked[g])
        );
    end

    assign bank_busy = bank_active | bank_locked;

    logic [BA_W-1:0] first_busy, first_locked;
    logic            bad;

    always_comb begin
        first_busy   = '0;
        first_locked = '0;
        for (int i = NUM_BANKS - 1; i >= 0; i--) begin
            if (bank_busy[i])   first_busy   = BA_W'(i);
            if (bank_locked[i]) first_locked = BA_W'(i);
        end
    end

    always_comb begin
        state_d      = state_q;
        state_d.cke  = cke;
        state_d.code = dec_cmd;
        state_d.bank = '0;
        bad          = 1'b0;
        op_act       = '0;
        op_pre       = '0;
        op_rd_ap     = '0;
        op_wr_ap     = '0;

        unique case (dec_cmd)
            CMD_ACT: begin
                bad          = bank_active[ba] | bank_locked[ba];
                state_d.bank = ba;
            end
            CMD_RD, CMD_RDA, CMD_WR, CMD_WRA: begin
                bad          = !bank_active[ba] | bank_locked[ba];
                state_d.bank = ba;
            end
            CMD_PRE: begin
                bad          = bank_locked[ba];
                state_d.bank = ba;
            end
            CMD_PREA: begin
                bad          = |bank_locked;
                state_d.bank = first_locked;
            end
            CMD_MRS, CMD_EMRS, CMD_REF: begin
                bad          = |bank_busy;
                state_d.bank = first_busy;
            end
            default: bad = 1'b0;
        endcase

        if (!bad) begin
            state_d.bank = '0;
            unique case (dec_cmd)
                CMD_ACT:  op_act[ba]   = 1'b1;
                CMD_RDA:  op_rd_ap[ba] = 1'b1;
                CMD_WRA:  op_wr_ap[ba] = 1'b1;
                CMD_PRE:  op_pre[ba]   = 1'b1;
                CMD_PREA: op_pre       = '1;
                default:  op_pre       = '0;
            endcase
        end
        state_d.viol = bad;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '{code: CMD_DESEL, viol: 1'b0, bank: '0, cke: 1'b0};
        end else begin
            state_q <= state_d;
        end
    end

    assign cmd_code  = state_q.code;
    assign viol      = state_q.viol;
    assign viol_bank = state_q.bank;

    // R1: a deselected cycle is never reported as illegal
    p_desel_clean_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.code == CMD_DESEL) |-> !state_q.viol);

    // R12: a held cycle is never reported as illegal
    p_hold_clean_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.code == CMD_HOLD) |-> !state_q.viol);

    // R10: at most one bank is opened per cycle
    p_single_open_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(op_act));

    // R11: no bank is reported when the flag is low
    p_bank_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !state_q.viol |-> (state_q.bank == '0));

endmodule

// File: tb/ddr_cmd_guard_tb.sv
module ddr_cmd_guard_tb;

    localparam int BURST_LEN = 4;
    localparam int T_RP      = 3;
    localparam int T_WR      = 2;
    localparam int LR        = BURST_LEN / 2 + T_RP;
    localparam int LW        = BURST_LEN / 2 + 1 + T_WR + T_RP;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cke = 1'b1;
    logic       cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic       a10 = 1'b0;
    logic [1:0] ba = '0;
    logic [3:0] cmd_code;
    logic       viol;
    logic [1:0] viol_bank;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    ddr_cmd_guard #(.BURST_LEN(BURST_LEN), .T_RP(T_RP), .T_WR(T_WR), .BA_W(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .a10(a10), .ba(ba),
        .cmd_code(cmd_code), .viol(viol), .viol_bank(viol_bank)
    );

    // kind numbers equal the expected code of that command
    task automatic set_pins(input int kind, input logic [1:0] bank);
        logic [3:0] p;
        case (kind)
            0:       p = 4'b1010;
            2, 3:    p = 4'b0000;
            4:       p = 4'b0001;
            5:       p = 4'b0011;
            6, 7:    p = 4'b0010;
            8, 9:    p = 4'b0101;
            10, 11:  p = 4'b0100;
            12:      p = 4'b0110;
            default: p = 4'b0111;
        endcase
        {cs_n, ras_n, cas_n, we_n} = p;
        a10 = (kind == 7 || kind == 9 || kind == 11);
        ba  = bank;
    endtask

    task automatic check(input int ecode, input logic ev, input logic [1:0] eb, input string tag);
        checks++;
        if (cmd_code !== 4'(ecode) || viol !== ev || (ev && viol_bank !== eb)) begin
            errors++;
            $display("FAIL %s: got code=%0d viol=%0b bank=%0d, expected code=%0d viol=%0b bank=%0d",
                     tag, cmd_code, viol, viol_bank, ecode, ev, eb);
        end
    endtask

    task automatic step(input int kind, input logic [1:0] bank, input int ecode,
                        input logic ev, input logic [1:0] eb, input string tag);
        set_pins(kind, bank);
        @(negedge clk);
        check(ecode, ev, eb, tag);
    endtask

    // {kind[12:9], ba[8:7], code[6:3], viol[2], bank[1:0]}
    localparam logic [12:0] VEC [24] = '{
        {4'd1,  2'd0, 4'd1,  1'b0, 2'd0},  // R2 nop
        {4'd2,  2'd0, 4'd2,  1'b0, 2'd0},  // R7 mode write legal
        {4'd3,  2'd1, 4'd3,  1'b0, 2'd0},  // R2 extended mode write
        {4'd4,  2'd0, 4'd4,  1'b0, 2'd0},  // R9 refresh legal
        {4'd8,  2'd2, 4'd8,  1'b1, 2'd2},  // R8 read closed bank
        {4'd5,  2'd1, 4'd5,  1'b0, 2'd0},  // R2 activate
        {4'd5,  2'd1, 4'd5,  1'b1, 2'd1},  // R8 activate open bank
        {4'd2,  2'd0, 4'd2,  1'b1, 2'd1},  // R7 mode write with open bank
        {4'd4,  2'd0, 4'd4,  1'b1, 2'd1},  // R9 refresh with open bank
        {4'd8,  2'd1, 4'd8,  1'b0, 2'd0},  // R2 read
        {4'd10, 2'd1, 4'd10, 1'b0, 2'd0},  // R2 write
        {4'd12, 2'd0, 4'd12, 1'b0, 2'd0},  // R2 burst stop
        {4'd0,  2'd3, 4'd0,  1'b0, 2'd0},  // R1 deselect
        {4'd6,  2'd1, 4'd6,  1'b0, 2'd0},  // R6 single precharge
        {4'd5,  2'd1, 4'd5,  1'b1, 2'd1},  // R6 inside precharge lock
        {4'd5,  2'd0, 4'd5,  1'b0, 2'd0},  // R5 other bank free
        {4'd5,  2'd1, 4'd5,  1'b0, 2'd0},  // R10 flagged activate was dropped
        {4'd7,  2'd2, 4'd7,  1'b0, 2'd0},  // R6 precharge-all
        {4'd5,  2'd2, 4'd5,  1'b0, 2'd0},  // R6 BA ignored by precharge-all
        {4'd5,  2'd0, 4'd5,  1'b1, 2'd0},  // R6 bank0 locked
        {4'd1,  2'd0, 4'd1,  1'b0, 2'd0},  // R2 nop
        {4'd5,  2'd0, 4'd5,  1'b0, 2'd0},  // R6 lock over
        {4'd7,  2'd0, 4'd7,  1'b0, 2'd0},  // R6 precharge-all
        {4'd4,  2'd0, 4'd4,  1'b1, 2'd0}   // R11 lowest bank at fault
    };

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got no finish, expected finish");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(0, 1'b0, 2'd0, "R13 reset outputs");
        rst_n = 1'b1;
        step(1, 2'd0, 13, 1'b0, 2'd0, "R13 clock-enable low after reset");

        for (int i = 0; i < 24; i++) begin
            step(int'(VEC[i][12:9]), VEC[i][8:7], int'(VEC[i][6:3]),
                 VEC[i][2], VEC[i][1:0], $sformatf("R2 vector %0d", i));
        end

        repeat (4) step(1, 2'd0, 1, 1'b0, 2'd0, "R2 nop");

        // R3 read auto-precharge window
        step(5, 2'd3, 5, 1'b0, 2'd0, "R3 open bank3");
        step(9, 2'd3, 9, 1'b0, 2'd0, "R3 read auto-precharge");
        for (int k = 1; k < LR; k++)
            step(5, 2'd3, 5, 1'b1, 2'd3, "R3 inside read lock");
        step(5, 2'd3, 5, 1'b0, 2'd0, "R3 read lock over");

        // R4 write auto-precharge window, R5 other bank
        step(5, 2'd2, 5, 1'b0, 2'd0, "R4 open bank2");
        step(11, 2'd2, 11, 1'b0, 2'd0, "R4 write auto-precharge");
        step(5, 2'd1, 5, 1'b0, 2'd0, "R5 bank1 during bank2 lock");
        for (int k = 2; k < LW; k++)
            step(6, 2'd2, 6, 1'b1, 2'd2, "R4 inside write lock");
        step(5, 2'd2, 5, 1'b0, 2'd0, "R4 write lock over");

        // R12 clock-enable hold
        cke = 1'b0;
        step(1, 2'd0, 1, 1'b0, 2'd0, "R12 cycle with cke falling");
        cke = 1'b1;
        step(5, 2'd0, 13, 1'b0, 2'd0, "R12 held activate");
        step(5, 2'd0, 5, 1'b0, 2'd0, "R12 held activate dropped");
        step(5, 2'd0, 5, 1'b1, 2'd0, "R8 bank0 now open");

        // R13 mid-run reset clears open banks
        rst_n = 1'b0;
        @(negedge clk);
        check(0, 1'b0, 2'd0, "R13 reset outputs mid-run");
        rst_n = 1'b1;
        step(1, 2'd0, 13, 1'b0, 2'd0, "R13 hold after reset");
        step(5, 2'd1, 5, 1'b0, 2'd0, "R13 bank1 closed by reset");

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule